// File: doc/BRIEF.md
# Frame-Synchronised Window Configuration Bank

This block holds the configuration of several display overlay windows as register pairs. Software writes a pending copy of each field through a simple write port. The display pipeline sees only the live copy. On a one-cycle frame-sync strobe, the pending copy of each window is moved into its live copy. Each window has a hold bit. While the hold bit is set, none of that window's fields move at the strobe. Software sets the hold bit, rewrites any number of fields, then clears it. The whole new set then takes effect together at the next frame boundary, so a half-updated window is never displayed.

Each window has these fields:
- a control field with an enable bit and a 3-bit format code;
- a top-left origin;
- a size;
- a buffer base address;
- for every window except window 0, an alpha value and a colour-key value.

The live origin and size are also presented as inclusive left, top, right and bottom edges. A shared control word holds the per-window hold bits and the per-window DMA channel enables. The channel enables act at once and are not frame-synchronised. Reads of a field address return the pending copy. A parallel set of read-only addresses returns the live copy.

Address layout (7 bits):
- bit 6 selects the live view;
- bits 5:3 give the window number;
- bits 2:0 give the field.

Top module: `win_shadow_bank`

## Requirements
- R1: Reset clears every pending field, every live field, all hold bits and all channel enables; afterwards every field read and the control word read return 0.
- R2: A write to address {0, window, field} updates the pending field on that clock edge. The field is read back masked: control keeps bits [3:0], origin and size keep bits [COORD_W-1:0] and [16+COORD_W-1:16], and base, alpha and key keep all 32 bits. The live outputs do not change until a frame-sync strobe.
- R3: The field codes are: control 0 (bit 0 enable, bits [3:1] format), origin 1 (x low half, y high half), size 2 (width low half, height high half), base 3, alpha 4, key 5. When `vsync` is high at a clock edge and a window's hold bit is 0, all of that window's pending fields become live on that edge.
- R4: When a window's hold bit is 1 at a `vsync` edge, none of that window's live fields change. Windows whose hold bits are 0 still update on that edge.
- R5: After a hold bit is cleared, the values still pending for that window stay out of the live copy until the next `vsync` edge, and become live on that edge.
- R6: Window 0 has no alpha or key field. Writes to window-0 field 4 or field 5 are ignored, those addresses read 0, and the window-0 alpha and key outputs stay 0.
- R7: The live edges are: right = left + width - 1 and bottom = top + height - 1, both modulo 2^COORD_W, with left and top inclusive.
- R8: Address {1, window, field} reads the live copy of that field. Writes to these live-view addresses are ignored.
- R9: The control word sits at address 0x38. Bits [4:0] are the per-window hold bits and bits [12:8] are the channel enables. The control word reads back as written in those bits. A channel enable drives `chanEnable` from the edge of the write, without waiting for `vsync` and regardless of the hold bits.
- R10: Clearing a window's enable bit while the window is held leaves `winEnable` set. The bit clears only at the first `vsync` edge after the hold bit is released.
- R11: When a write to a field and a `vsync` edge fall on the same clock edge, the live copy takes the pending value from before the write. The new value becomes live at the following `vsync` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 7 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 7 | Read address |
| rdData | output | 32 | Combinational read data |
| vsync | input | 1 | One-cycle frame-boundary strobe |
| winEnable | output | 5 | Live enable bit per window |
| winFormat | output | 5x3 | Live format code per window |
| winBase | output | 5x32 | Live buffer base address per window |
| winLeft | output | 5xCOORD_W | Live left edge (inclusive) per window |
| winTop | output | 5xCOORD_W | Live top edge (inclusive) per window |
| winRight | output | 5xCOORD_W | Live right edge (inclusive) per window |
| winBottom | output | 5xCOORD_W | Live bottom edge (inclusive) per window |
| winAlpha | output | 5x32 | Live alpha value per window (0 for window 0) |
| winKey | output | 5x32 | Live colour-key value per window (0 for window 0) |
| chanEnable | output | 5 | Channel enable per window (takes effect immediately) |

## Verification
The assertions assume that `vsync` is a strobe synchronous to `clk`, and that software sets a window's hold bit before starting a multi-field update. They also assume that size fields are nonzero wherever the edge outputs matter, because a zero size wraps the right and bottom edges. The stimulus raises `vsync` for exactly one cycle, always between writes or on purpose together with a single write. It programs every size it checks with a nonzero width and height; the reset state is the only case with a zero size.

// File: rtl/win_shadow_pkg.sv
package win_shadow_pkg;
  // Window and field geometry of the bank.
  localparam int WIN_NUM   = 5;
  localparam int FIELD_NUM = 6;
  localparam int ADDR_W    = 7;
  localparam int CHAN_LSB  = 8;

  localparam int F_CTRL   = 0;
  localparam int F_ORIGIN = 1;
  localparam int F_SIZE   = 2;
  localparam int F_BASE   = 3;
  localparam int F_ALPHA  = 4;
  localparam int F_KEY    = 5;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h38;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [WIN_NUM-1:0][FIELD_NUM-1:0] wr;
    logic [WIN_NUM-1:0]                latch;
  } bankStrobe_t;

  // Window 0 carries no alpha or key field.
  function automatic logic fieldExists(input int w, input int f);
    return (w < WIN_NUM) && (f < FIELD_NUM) && !(w == 0 && f >= F_ALPHA);
  endfunction
endpackage

// File: rtl/win_shadow_ctrl.sv
module win_shadow_ctrl
  import win_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [WIN_NUM-1:0]     protectIn,
  input  logic [WIN_NUM-1:0]     chanIn,
  input  logic                   vsync,
  output bankStrobe_t            strobes,
  output logic [DATA_W-1:0]      ctrlWord,
  output logic [WIN_NUM-1:0]     chanEnable
);
  logic [WIN_NUM-1:0] protectQ;
  logic [WIN_NUM-1:0] chanQ;
  logic               ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == CTRL_ADDR);

  always_comb begin
    strobes = '0;
    for (int w = 0; w < WIN_NUM; w++) begin
      for (int f = 0; f < FIELD_NUM; f++) begin
        strobes.wr[w][f] = wrEn && !wrAddr[6] && (wrAddr[5:3] == 3'(w))
                           && (wrAddr[2:0] == 3'(f)) && fieldExists(w, f);
      end
      strobes.latch[w] = vsync && !protectQ[w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protectQ <= '0;
      chanQ    <= '0;
    end else if (ctrlWr) begin
      protectQ <= protectIn;
      chanQ    <= chanIn;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[WIN_NUM-1:0] = protectQ;
    ctrlWord[CHAN_LSB +: WIN_NUM] = chanQ;
  end

  assign chanEnable = chanQ;

  // R9
  chan_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (chanEnable == $past(chanIn)));

  // R1
  ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(ctrlWord));
endmodule

// File: rtl/win_shadow_data.sv
module win_shadow_data
  import win_shadow_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  bankStrobe_t                          strobes,
  input  logic [DATA_W-1:0]                    wrData,
  input  logic [ADDR_W-1:0]                    rdAddr,
  input  logic [DATA_W-1:0]                    ctrlWord,
  output logic [DATA_W-1:0]                    rdData,
  output logic [WIN_NUM-1:0]                   winEnable,
  output logic [WIN_NUM-1:0][2:0]              winFormat,
  output logic [WIN_NUM-1:0][DATA_W-1:0]       winBase,
  output logic [WIN_NUM-1:0][COORD_W-1:0]      winLeft,
  output logic [WIN_NUM-1:0][COORD_W-1:0]      winTop,
  output logic [WIN_NUM-1:0][COORD_W-1:0]      winRight,
  output logic [WIN_NUM-1:0][COORD_W-1:0]      winBottom,
  output logic [WIN_NUM-1:0][DATA_W-1:0]       winAlpha,
  output logic [WIN_NUM-1:0][DATA_W-1:0]       winKey
);
  localparam int HALF = 16;
  localparam logic [DATA_W-1:0] COORD_MASK =
    {{(DATA_W-COORD_W){1'b0}}, {COORD_W{1'b1}}};

  logic [WIN_NUM-1:0][FIELD_NUM-1:0][DATA_W-1:0] shadowQ;
  logic [WIN_NUM-1:0][FIELD_NUM-1:0][DATA_W-1:0] activeQ;

  function automatic logic [DATA_W-1:0] fieldMask(input int f);
    case (f)
      F_CTRL:           return DATA_W'(4'hF);
      F_ORIGIN, F_SIZE: return COORD_MASK | (COORD_MASK << HALF);
      default:          return '1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      for (int w = 0; w < WIN_NUM; w++) begin
        for (int f = 0; f < FIELD_NUM; f++) begin
          if (strobes.wr[w][f]) shadowQ[w][f] <= wrData & fieldMask(f);
          if (strobes.latch[w]) activeQ[w][f] <= shadowQ[w][f];
        end
      end
    end
  end

  // Read mux: pending view, live view, control word.
  always_comb begin
    rdData = '0;
    if (rdAddr == CTRL_ADDR) begin
      rdData = ctrlWord;
    end else if (int'(rdAddr[5:3]) < WIN_NUM && int'(rdAddr[2:0]) < FIELD_NUM) begin
      if (rdAddr[6]) rdData = activeQ[rdAddr[5:3]][rdAddr[2:0]];
      else           rdData = shadowQ[rdAddr[5:3]][rdAddr[2:0]];
    end
  end

  for (genvar w = 0; w < WIN_NUM; w++) begin : g_out
    logic [COORD_W-1:0] sizeW;
    logic [COORD_W-1:0] sizeH;
    assign sizeW        = activeQ[w][F_SIZE][COORD_W-1:0];
    assign sizeH        = activeQ[w][F_SIZE][HALF +: COORD_W];
    assign winEnable[w] = activeQ[w][F_CTRL][0];
    assign winFormat[w] = activeQ[w][F_CTRL][3:1];
    assign winBase[w]   = activeQ[w][F_BASE];
    assign winLeft[w]   = activeQ[w][F_ORIGIN][COORD_W-1:0];
    assign winTop[w]    = activeQ[w][F_ORIGIN][HALF +: COORD_W];
    assign winRight[w]  = winLeft[w] + sizeW - COORD_W'(1);
    assign winBottom[w] = winTop[w] + sizeH - COORD_W'(1);
    assign winAlpha[w]  = activeQ[w][F_ALPHA];
    assign winKey[w]    = activeQ[w][F_KEY];

    // R3
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.latch[w] |=> (activeQ[w] == $past(shadowQ[w])));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.latch[w] |=> $stable(activeQ[w]));
  end

  // R6
  win0_no_extra_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winAlpha[0] == '0) && (winKey[0] == '0) && (shadowQ[0][F_ALPHA] == '0));
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import win_shadow_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [ADDR_W-1:0]                rdAddr,
  output logic [DATA_W-1:0]                rdData,
  input  logic                             vsync,
  output logic [WIN_NUM-1:0]               winEnable,
  output logic [WIN_NUM-1:0][2:0]          winFormat,
  output logic [WIN_NUM-1:0][DATA_W-1:0]   winBase,
  output logic [WIN_NUM-1:0][COORD_W-1:0]  winLeft,
  output logic [WIN_NUM-1:0][COORD_W-1:0]  winTop,
  output logic [WIN_NUM-1:0][COORD_W-1:0]  winRight,
  output logic [WIN_NUM-1:0][COORD_W-1:0]  winBottom,
  output logic [WIN_NUM-1:0][DATA_W-1:0]   winAlpha,
  output logic [WIN_NUM-1:0][DATA_W-1:0]   winKey,
  output logic [WIN_NUM-1:0]               chanEnable
);
  bankStrobe_t         strobes;
  logic [DATA_W-1:0]   ctrlWord;

  win_shadow_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .protectIn  (wrData[WIN_NUM-1:0]),
    .chanIn     (wrData[CHAN_LSB +: WIN_NUM]),
    .vsync      (vsync),
    .strobes    (strobes),
    .ctrlWord   (ctrlWord),
    .chanEnable (chanEnable)
  );

  win_shadow_data #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .ctrlWord  (ctrlWord),
    .rdData    (rdData),
    .winEnable (winEnable),
    .winFormat (winFormat),
    .winBase   (winBase),
    .winLeft   (winLeft),
    .winTop    (winTop),
    .winRight  (winRight),
    .winBottom (winBottom),
    .winAlpha  (winAlpha),
    .winKey    (winKey)
  );

  for (genvar w = 0; w < WIN_NUM; w++) begin : g_hold
    // R4
    protected_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (vsync && ctrlWord[w]) |=> ($stable(winBase[w]) && $stable(winEnable[w])
                                  && $stable(winLeft[w]) && $stable(winAlpha[w])));
  end
endmodule

// File: tb/win_shadow_bank_bench.sv
`timescale 1ns/1ps
module win_shadow_bank_bench;
  localparam int NW = 5;
  localparam int CW = 12;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_VS = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  // Address = {live, window[2:0], field[2:0]}; control word at 0x38.
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 7'h0B, 32'h1000_0040, 4'd2},  // w1 base
    '{OP_RD, 7'h0B, 32'h1000_0040, 4'd2},  // R2 pending readback
    '{OP_RD, 7'h4B, 32'h0000_0000, 4'd2},  // R2 live unchanged
    '{OP_WR, 7'h09, 32'h0014_000A, 4'd2},  // w1 origin
    '{OP_WR, 7'h0A, 32'h0030_0040, 4'd2},  // w1 size
    '{OP_WR, 7'h08, 32'h0000_0005, 4'd2},  // w1 ctrl en=1 fmt=2
    '{OP_VS, 7'h00, 32'h0,         4'd3},
    '{OP_RD, 7'h4B, 32'h1000_0040, 4'd3},  // R3
    '{OP_RD, 7'h49, 32'h0014_000A, 4'd3},
    '{OP_RD, 7'h48, 32'h0000_0005, 4'd3},
    '{OP_WR, 7'h38, 32'h0000_0002, 4'd4},  // hold w1
    '{OP_WR, 7'h0B, 32'h2000_0000, 4'd4},
    '{OP_WR, 7'h0C, 32'h00AB_CDEF, 4'd4},
    '{OP_WR, 7'h13, 32'h0000_3000, 4'd4},  // w2 base, not held
    '{OP_VS, 7'h00, 32'h0,         4'd4},
    '{OP_RD, 7'h4B, 32'h1000_0040, 4'd4},  // R4 held
    '{OP_RD, 7'h4C, 32'h0000_0000, 4'd4},
    '{OP_RD, 7'h53, 32'h0000_3000, 4'd4},  // R4 other window moves
    '{OP_WR, 7'h38, 32'h0000_0000, 4'd5},  // release
    '{OP_RD, 7'h4B, 32'h1000_0040, 4'd5},  // R5 still waiting
    '{OP_VS, 7'h00, 32'h0,         4'd5},
    '{OP_RD, 7'h4B, 32'h2000_0000, 4'd5},  // R5
    '{OP_RD, 7'h4C, 32'h00AB_CDEF, 4'd5},
    '{OP_WR, 7'h04, 32'hFFFF_FFFF, 4'd6},  // w0 alpha absent
    '{OP_WR, 7'h05, 32'hFFFF_FFFF, 4'd6},  // w0 key absent
    '{OP_RD, 7'h04, 32'h0000_0000, 4'd6},  // R6
    '{OP_VS, 7'h00, 32'h0,         4'd6},
    '{OP_RD, 7'h45, 32'h0000_0000, 4'd6},
    '{OP_WR, 7'h49, 32'h0000_1234, 4'd8},  // write to live view
    '{OP_RD, 7'h49, 32'h0014_000A, 4'd8},  // R8
    '{OP_RD, 7'h09, 32'h0014_000A, 4'd8},
    '{OP_WR, 7'h21, 32'hFFFF_FFFF, 4'd2},  // w4 origin masked
    '{OP_RD, 7'h21, 32'h0FFF_0FFF, 4'd2}   // R2 mask
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [6:0] rdAddr = '0;
  logic [31:0] rdData;
  logic vsync = 1'b0;
  logic [NW-1:0] winEnable;
  logic [NW-1:0][2:0] winFormat;
  logic [NW-1:0][31:0] winBase;
  logic [NW-1:0][CW-1:0] winLeft, winTop, winRight, winBottom;
  logic [NW-1:0][31:0] winAlpha, winKey;
  logic [NW-1:0] chanEnable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_shadow_bank #(.DATA_W(32), .COORD_W(CW)) u_win_shadow_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .vsync(vsync),
    .winEnable(winEnable), .winFormat(winFormat), .winBase(winBase),
    .winLeft(winLeft), .winTop(winTop), .winRight(winRight), .winBottom(winBottom),
    .winAlpha(winAlpha), .winKey(winKey), .chanEnable(chanEnable)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic wrPulse(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; vsync = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; vsync = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(7'h38, 32'h0, "R1 ctrl word");
    rd(7'h4B, 32'h0, "R1 live base");
    check("R1 winEnable", 32'(winEnable), 32'h0);
    check("R1 chanEnable", 32'(chanEnable), 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: wr(VEC[i].addr, VEC[i].data);
        OP_VS: pulse();
        default: rd(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec %0d", VEC[i].req, i));
      endcase
    end

    // R6 window 0 outputs
    check("R6 winAlpha0", winAlpha[0], 32'h0);
    check("R6 winKey0", winKey[0], 32'h0);

    // R7 inclusive edges
    check("R7 left", 32'(winLeft[1]), 32'd10);
    check("R7 right", 32'(winRight[1]), 32'd73);
    check("R7 bottom", 32'(winBottom[1]), 32'd67);
    wr(7'h19, 32'h0001_0FF0);
    wr(7'h1A, 32'h0001_0020);
    pulse();
    check("R7 right wrap", 32'(winRight[3]), 32'h00F);
    check("R7 bottom one", 32'(winBottom[3]), 32'h001);

    // R9 channel enables act at once
    wr(7'h38, 32'h0000_1F00);
    check("R9 chanEnable", 32'(chanEnable), 32'h1F);
    check("R9 winEnable", 32'(winEnable), 32'h02);
    rd(7'h38, 32'h0000_1F00, "R9 ctrl readback");

    // R10 disable while held
    wr(7'h38, 32'h0000_1F02);
    wr(7'h08, 32'h0);
    pulse();
    check("R10 held enable", 32'(winEnable[1]), 32'h1);
    wr(7'h38, 32'h0000_1F00);
    check("R10 released no sync", 32'(winEnable[1]), 32'h1);
    pulse();
    check("R10 after sync", 32'(winEnable[1]), 32'h0);
    check("R9 chan kept", 32'(chanEnable), 32'h1F);

    // R11 write on the sync edge
    wr(7'h13, 32'h5);
    wrPulse(7'h13, 32'hA);
    check("R11 live old value", winBase[2], 32'h5);
    rd(7'h13, 32'hA, "R11 pending new value");
    pulse();
    check("R11 next sync", winBase[2], 32'hA);

    // R1 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(7'h38, 32'h0, "R1 ctrl after reset");
    rd(7'h13, 32'h0, "R1 pending after reset");
    check("R1 live base after reset", winBase[2], 32'h0);
    check("R1 chan after reset", 32'(chanEnable), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule